// File: doc/BRIEF.md
# NPC Leg Dead-Time Generator

This block sits between a modulator and the four gate drivers of one phase leg of a three-level neutral-point-clamped inverter. It receives the two raw commands for the upper switches, S1 and S2. It produces all four gate lines. S3 is driven as the complement of S1, and S4 as the complement of S2. The pairs are S1/S3 and S2/S4, not adjacent switches.

At every change of a raw command, the switch that was conducting is released at the next clock edge. The incoming switch of that pair is released only after a programmable number of clocks in which both are low. A nominal setting is 10 clocks, which is 1 µs at 10 MHz.

Two qualifiers gate the whole leg: a global enable and an input-valid flag from an upstream safety check. While either is low, every gate line is held low. When both become true, the leg stays dark for one full dead-time interval before it follows the commands. The dead-time setting is captured only while the enable is low.

Top module: `npc_leg_deadtime`

## Requirements
- R1: During and right after reset all four gate lines are low. The captured dead time after reset is DT_RST (10) clocks.
- R2: In steady state, gate_s1 equals the S1 command and gate_s3 its inverse. Likewise, gate_s2 equals the S2 command and gate_s4 its inverse.
- R3: When a raw command sampled at a clock edge differs from the one sampled at the previous edge, both gate lines of that pair are low from that edge on.
- R4: After a command change sampled at edge E, the incoming gate line rises at edge E+D, where D is the captured dead time. Both lines of the pair are low for exactly D cycles.
- R5: A command that changes again before its dead time has run out restarts the D-cycle count from the new change. The two lines of a pair are never high in the same cycle.
- R6: An edge at which en or in_ok is low drives all four gate lines low.
- R7: At the first edge where en and in_ok are both high after either was low, all lines stay low. The lines follow the commands only from D edges later.
- R8: dead_cnt is captured on every edge at which en is low. Changes to it while en is high have no effect on the timing.
- R9: A dead_cnt value of zero is captured as one clock.
- R10: The two pairs are timed independently. A change on one command does not disturb the other pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Global enable, low forces all gates off |
| in_ok | input | 1 | Input-valid flag from the safety check |
| cmd_s1 | input | 1 | Raw command for upper switch S1 |
| cmd_s2 | input | 1 | Raw command for upper switch S2 |
| dead_cnt | input | CNT_W | Dead time in clocks, captured while en is low |
| gate_s1 | output | 1 | Gate of S1 |
| gate_s2 | output | 1 | Gate of S2 |
| gate_s3 | output | 1 | Gate of S3, complement of S1 |
| gate_s4 | output | 1 | Gate of S4, complement of S2 |

## Verification
A command change can fall on the same edge as the end of a running dead-time count, or on the same edge as the leg's activation. In both cases the restart must win, so that the pair stays dark for a fresh D cycles. The bench provokes both cases: it toggles a command back two cycles after a change, and it re-enables the leg while the commands are moving. A behavioural model counts edges since the last event and judges the gate lines on every cycle.

// File: rtl/npc_leg_deadtime.sv
module npc_leg_deadtime #(
  parameter int CNT_W  = 8,
  parameter int DT_RST = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             in_ok,
  input  logic             cmd_s1,
  input  logic             cmd_s2,
  input  logic [CNT_W-1:0] dead_cnt,
  output logic             gate_s1,
  output logic             gate_s2,
  output logic             gate_s3,
  output logic             gate_s4
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] dt_q;
  logic             run, run_q;
  logic [1:0]       cmd_v, hi_q, lo_q;

  assign run   = en & in_ok;
  assign cmd_v = {cmd_s2, cmd_s1};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dt_q  <= CNT_W'(DT_RST);
      run_q <= 1'b0;
    end else begin
      run_q <= run;
      if (!en) dt_q <= (dead_cnt == '0) ? ONE : dead_cnt;
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_pair
    logic             lvl_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lvl_q   <= 1'b0;
        cnt_q   <= '0;
        hi_q[p] <= 1'b0;
        lo_q[p] <= 1'b0;
      end else begin
        lvl_q <= cmd_v[p];
        if (!run) begin
          hi_q[p] <= 1'b0;
          lo_q[p] <= 1'b0;
        end else if (!run_q || cmd_v[p] != lvl_q) begin
          cnt_q   <= dt_q - ONE;
          hi_q[p] <= 1'b0;
          lo_q[p] <= 1'b0;
        end else if (cnt_q != '0) begin
          cnt_q   <= cnt_q - ONE;
          hi_q[p] <= 1'b0;
          lo_q[p] <= 1'b0;
        end else begin
          hi_q[p] <= lvl_q;
          lo_q[p] <= ~lvl_q;
        end
      end
    end
  end

  assign gate_s1 = hi_q[0];
  assign gate_s3 = lo_q[0];
  assign gate_s2 = hi_q[1];
  assign gate_s4 = lo_q[1];
endmodule

// File: rtl/npc_leg_deadtime_chk.sv
module npc_leg_deadtime_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic in_ok,
  input logic cmd_s1,
  input logic cmd_s2,
  input logic gate_s1,
  input logic gate_s2,
  input logic gate_s3,
  input logic gate_s4
);
  logic any_on;
  assign any_on = gate_s1 | gate_s2 | gate_s3 | gate_s4;

  p_pair_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_s1 && gate_s3) && !(gate_s2 && gate_s4));

  p_idle_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && in_ok) |=> !any_on);

  p_start_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en && in_ok) |=> !any_on);

  p_break_s1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_s1 != $past(cmd_s1)) |=> !gate_s1 && !gate_s3);

  p_break_s2_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_s2 != $past(cmd_s2)) |=> !gate_s2 && !gate_s4);

  p_gap_s1_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_s1) || $rose(gate_s3)) |-> !$past(gate_s1) && !$past(gate_s3));

  p_gap_s2_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_s2) || $rose(gate_s4)) |-> !$past(gate_s2) && !$past(gate_s4));

  p_follow_s1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_s1 |-> $past(cmd_s1)) and (gate_s3 |-> !$past(cmd_s1)));

  p_follow_s2_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_s2 |-> $past(cmd_s2)) and (gate_s4 |-> !$past(cmd_s2)));
endmodule

bind npc_leg_deadtime npc_leg_deadtime_chk u_chk (.*);

// File: tb/npc_leg_deadtime_tb.sv
module npc_leg_deadtime_tb;
  localparam int CLK_NS = 10;
  localparam int CNT_W  = 8;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, in_ok = 1'b0;
  logic cmd_s1 = 1'b0, cmd_s2 = 1'b0;
  logic [CNT_W-1:0] dead_cnt = 8'd10;
  logic gate_s1, gate_s2, gate_s3, gate_s4;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit done = 0;

  npc_leg_deadtime #(.CNT_W(CNT_W), .DT_RST(10)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .in_ok(in_ok),
    .cmd_s1(cmd_s1), .cmd_s2(cmd_s2), .dead_cnt(dead_cnt),
    .gate_s1(gate_s1), .gate_s2(gate_s2), .gate_s3(gate_s3), .gate_s4(gate_s4));

  always #(CLK_NS/2) clk = ~clk;

  // behavioural model: edges since last event per pair
  int  age [2];
  bit  prev_cmd [2];
  bit  prev_act;
  int  dm;
  bit [3:0] exp_g;  // {s4,s3,s2,s1}

  always @(posedge clk) begin
    bit act;
    bit c [2];
    c[0] = cmd_s1; c[1] = cmd_s2;
    act = en && in_ok;
    if (!rst_n) begin
      exp_g = 4'b0; prev_act = 0; dm = 10;
      prev_cmd[0] = 0; prev_cmd[1] = 0; age[0] = 0; age[1] = 0;
    end else begin
      for (int p = 0; p < 2; p++) begin
        bit hi, lo;
        hi = 0; lo = 0;
        if (act) begin
          if (!prev_act || c[p] != prev_cmd[p]) age[p] = 1;
          else age[p] = age[p] + 1;
          if (age[p] > dm) begin hi = c[p]; lo = !c[p]; end
        end
        if (p == 0) begin exp_g[0] = hi; exp_g[2] = lo; end
        else        begin exp_g[1] = hi; exp_g[3] = lo; end
        prev_cmd[p] = c[p];
      end
      prev_act = act;
      if (!en) dm = (dead_cnt == 0) ? 1 : int'(dead_cnt);
    end
  end

  always @(negedge clk) begin
    bit [3:0] act_g;
    act_g = {gate_s4, gate_s3, gate_s2, gate_s1};
    if (!done) begin
      checks++;
      if (act_g !== exp_g) begin
        errors++;
        $display("FAIL %s t=%0t gates(s4..s1) actual=%b expected=%b", cur_req, $time, act_g, exp_g);
      end
      checks++;
      if ((gate_s1 && gate_s3) || (gate_s2 && gate_s4)) begin
        errors++;
        $display("FAIL R5 pair overlap actual=%b expected=no pair both high", act_g);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic finish_run;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    cur_req = "R1";
    step(3);
    checks++;
    if ({gate_s4, gate_s3, gate_s2, gate_s1} !== 4'b0) begin
      errors++;
      $display("FAIL R1 reset gates actual=%b expected=0000", {gate_s4, gate_s3, gate_s2, gate_s1});
    end
    rst_n = 1; step(2);
    // R1: default dead time of 10 after reset, dead_cnt held at 10
    cur_req = "R7"; dead_cnt = 8'd4; step(1);
    en = 1; in_ok = 1; step(12);
    cur_req = "R3"; cmd_s1 = 1; step(1);
    cur_req = "R4"; step(8);
    cur_req = "R10"; cmd_s2 = 1; step(3); cmd_s1 = 0; step(10);
    cur_req = "R5"; cmd_s1 = 1; step(2); cmd_s1 = 0; step(3); cmd_s1 = 1; step(1); cmd_s1 = 0; step(10);
    cur_req = "R8"; dead_cnt = 8'd9; step(1); cmd_s2 = 0; step(12);
    cur_req = "R6"; in_ok = 0; step(4); cmd_s1 = 1; in_ok = 1; step(10);
    en = 0; step(3);
    cur_req = "R9"; dead_cnt = 8'd0; step(2); en = 1; step(4);
    cmd_s1 = 0; step(2); cmd_s2 = 1; step(1); cmd_s2 = 0; step(3);
    en = 0; dead_cnt = 8'd20; step(2);
    cur_req = "R7"; cmd_s2 = 1; en = 1; step(1); cmd_s1 = 1; step(30);
    cur_req = "R2";
    for (int i = 0; i < 400; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 6) cmd_s1 = ~cmd_s1;
      if (r > 93) cmd_s2 = ~cmd_s2;
      if (r == 50) begin en = 0; dead_cnt = 8'($urandom_range(0, 6)); end
      if (r == 51) en = 1;
      if (r == 52) in_ok = ~in_ok;
      step(1);
    end
    en = 1; in_ok = 1; step(40);
    finish_run();
  end
endmodule